// File: doc/BRIEF.md
# Fetch Redirect Controller with Epoch Filtering

This block owns the fetch program counter of a two-stage pipeline and removes wrong-path work after a next-address misprediction without flushing anything. The fetch side holds the PC and a one-bit fetch epoch. Each cycle it either handles a pending redirect record, stalls, or issues the instruction at the current PC. An issued instruction goes into a small forward queue, tagged with its PC, the predicted next PC from an external next-address predictor, and the fetch epoch. The PC then advances to the predicted address.

The execute side holds a one-bit execute epoch and looks at the head of the forward queue. A head whose tag differs from the execute epoch is on the wrong path and is discarded. A head whose tag matches is committed. An external execution model supplies the real next PC, the control type and the taken outcome. A matching control transfer, or any matching instruction whose real next PC differs from the predicted one, writes a resolution record into a one-entry redirect slot. A misprediction also flips the execute epoch. On the next cycle fetch forwards the record to the predictor's update port and empties the slot. Fetch reloads its PC and flips its epoch only when the record is marked mispredicted.

Fetch actions are named FA_REDIRECT (record pending, highest priority), FA_STALL (hazard input high or forward queue full) and FA_ISSUE (otherwise). Execute actions are named EA_IDLE (queue empty), EA_HOLD (hold input high, or a record is needed while the slot is occupied), EA_DROP (tag mismatch), EA_RESOLVE (commit plus record) and EA_COMMIT (commit without record).

Top module: `fr_fetch_redirect`

## Requirements
- R1: While reset is low, the fetch PC equals RESET_PC (default 0), the fetch epoch is 0, and commit_o, drop_o and pu_valid_o are 0. The execute epoch also resets to 0.
- R2: With no record pending, hazard_i low and fewer than DEPTH (default 2) entries queued, issue_o is 1. Fetch then loads pq_npc_i into the PC at the next edge. The entry's PC and predicted PC later appear on ex_pc_o and ex_ppc_o.
- R3: When hazard_i is high, or DEPTH entries are queued, and no record is pending, issue_o is 0 and the PC holds.
- R4: A queue head whose epoch tag differs from the execute epoch is dequeued with drop_o high, commit_o low and no record written.
- R5: A matching head with ex_npc_i different from its predicted PC flips the execute epoch, and its record carries mispredict = 1.
- R6: A matching head with ex_type_i of jump (1), register jump (2) or branch (3), or with a mispredict, produces a record. The record is visible on pu_* for exactly one cycle, the cycle after the commit. It carries the PC, the real next PC, taken, mispredict and type. Type 0 means not a control transfer.
- R7: In a cycle with pu_valid_o high, no instruction is issued. If mispredict is set, the PC becomes pu_npc_o and the fetch epoch flips at the next edge.
- R8: A record with mispredict = 0 leaves the PC and the fetch epoch unchanged.
- R9: When ex_hold_i is high, nothing is committed or dropped. A matching head that needs a record waits while the redirect slot is occupied.
- R10: The sequence of commit_pc_o values equals the architectural path, in which each PC is followed by its real next PC. No wrong-path instruction is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hazard_i | input | 1 | Hazard stall request for fetch |
| pq_pc_o | output | AW | Fetch PC, also the predictor query address |
| pq_npc_i | input | AW | Predicted next PC for pq_pc_o |
| issue_o | output | 1 | Instruction at pq_pc_o issued this cycle |
| issue_epoch_o | output | 1 | Fetch epoch, the tag given to issued instructions |
| ex_hold_i | input | 1 | Execute hold, nothing leaves the queue |
| ex_pc_o | output | AW | PC of the queue head |
| ex_ppc_o | output | AW | Predicted next PC of the queue head |
| ex_npc_i | input | AW | Real next PC of the head |
| ex_type_i | input | 2 | Head control type: 0 none, 1 jump, 2 register jump, 3 branch |
| ex_taken_i | input | 1 | Head control transfer taken |
| commit_o | output | 1 | Head committed this cycle |
| commit_pc_o | output | AW | PC of the committed head |
| drop_o | output | 1 | Head discarded as wrong-path this cycle |
| pu_valid_o | output | 1 | Predictor update record valid |
| pu_pc_o | output | AW | Record instruction PC |
| pu_npc_o | output | AW | Record real next PC |
| pu_taken_o | output | 1 | Record taken flag |
| pu_mispred_o | output | 1 | Record mispredict flag |
| pu_type_o | output | 2 | Record control type |

## Verification
issue_o, commit_o, drop_o and ex_pc_o/ex_ppc_o are combinational in the current cycle. The new PC after an issue is due one edge later. A record shows on pu_* one cycle after the commit that produced it, and the PC reload from a mispredicted record shows one cycle after that. The bench sets inputs just after each rising edge and samples at the falling edge. Its behavioural model keeps the state left by the previous cycle, so each expectation is compared in the cycle it is due. Those state items are the pending record, the queued tags and both epochs. The program mixes a taken branch, a correct jump prediction, a not-taken branch, a register jump and a target-buffer collision on a plain instruction. A long hold window fills the forward queue.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [1:0] {
        CT_NONE   = 2'd0,
        CT_JUMP   = 2'd1,
        CT_JREG   = 2'd2,
        CT_BRANCH = 2'd3
    } ctrl_type_e;

    typedef enum logic [1:0] {
        FA_ISSUE,
        FA_STALL,
        FA_REDIRECT
    } fetch_act_e;

    typedef enum logic [2:0] {
        EA_IDLE,
        EA_HOLD,
        EA_DROP,
        EA_COMMIT,
        EA_RESOLVE
    } exec_act_e;

endpackage

// File: rtl/fr_fwd_queue.sv
module fr_fwd_queue #(
    parameter int DW    = 65,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] slot [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign rdata = slot[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            slot[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/fr_fetch_unit.sv
module fr_fetch_unit
    import fr_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redir_valid,
    input  logic          redir_mispred,
    input  logic [AW-1:0] redir_npc,
    input  logic          hazard,
    input  logic          q_full,
    input  logic [AW-1:0] pred_npc,
    output logic [AW-1:0] pc,
    output logic          epoch,
    output logic          issue,
    output logic          redir_deq
);
    fetch_act_e act;

    always_comb begin
        if (redir_valid) begin
            act = FA_REDIRECT;
        end else if (hazard || q_full) begin
            act = FA_STALL;
        end else begin
            act = FA_ISSUE;
        end
    end

    always_comb begin
        issue     = 1'b0;
        redir_deq = 1'b0;
        unique case (act)
            FA_ISSUE:    issue     = 1'b1;
            FA_REDIRECT: redir_deq = 1'b1;
            FA_STALL:    ;
            default:     ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= RESET_PC;
            epoch <= 1'b0;
        end else begin
            unique case (act)
                FA_ISSUE: pc <= pred_npc;
                FA_REDIRECT: begin
                    if (redir_mispred) begin
                        pc    <= redir_npc;
                        epoch <= ~epoch;
                    end
                end
                FA_STALL: ;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/fr_exec_unit.sv
module fr_exec_unit
    import fr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_valid,
    input  logic [AW-1:0] head_pc,
    input  logic [AW-1:0] head_ppc,
    input  logic          head_ep,
    input  logic          hold,
    input  logic [AW-1:0] act_npc,
    input  ctrl_type_e    act_type,
    input  logic          act_taken,
    input  logic          rq_deq,
    output logic          pop,
    output logic          commit,
    output logic          drop,
    output logic          rq_valid,
    output logic [AW-1:0] rq_pc,
    output logic [AW-1:0] rq_npc,
    output logic          rq_taken,
    output logic          rq_mispred,
    output ctrl_type_e    rq_type
);
    exec_act_e act;
    logic      eepoch;
    logic      mispred;
    logic      needs_rec;

    assign mispred   = (act_npc != head_ppc);
    assign needs_rec = (act_type != CT_NONE) || mispred;

    always_comb begin
        if (!head_valid) begin
            act = EA_IDLE;
        end else if (hold) begin
            act = EA_HOLD;
        end else if (head_ep != eepoch) begin
            act = EA_DROP;
        end else if (needs_rec && rq_valid) begin
            act = EA_HOLD;
        end else if (needs_rec) begin
            act = EA_RESOLVE;
        end else begin
            act = EA_COMMIT;
        end
    end

    always_comb begin
        pop    = 1'b0;
        commit = 1'b0;
        drop   = 1'b0;
        unique case (act)
            EA_DROP: begin
                pop  = 1'b1;
                drop = 1'b1;
            end
            EA_COMMIT, EA_RESOLVE: begin
                pop    = 1'b1;
                commit = 1'b1;
            end
            EA_IDLE, EA_HOLD: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eepoch     <= 1'b0;
            rq_valid   <= 1'b0;
            rq_pc      <= '0;
            rq_npc     <= '0;
            rq_taken   <= 1'b0;
            rq_mispred <= 1'b0;
            rq_type    <= CT_NONE;
        end else begin
            if (act == EA_RESOLVE) begin
                rq_valid   <= 1'b1;
                rq_pc      <= head_pc;
                rq_npc     <= act_npc;
                rq_taken   <= act_taken;
                rq_mispred <= mispred;
                rq_type    <= act_type;
                if (mispred) begin
                    eepoch <= ~eepoch;
                end
            end else if (rq_deq) begin
                rq_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fr_fetch_redirect.sv
module fr_fetch_redirect
    import fr_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            DEPTH    = 2,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hazard_i,
    output logic [AW-1:0] pq_pc_o,
    input  logic [AW-1:0] pq_npc_i,
    output logic          issue_o,
    output logic          issue_epoch_o,
    input  logic          ex_hold_i,
    output logic [AW-1:0] ex_pc_o,
    output logic [AW-1:0] ex_ppc_o,
    input  logic [AW-1:0] ex_npc_i,
    input  logic [1:0]    ex_type_i,
    input  logic          ex_taken_i,
    output logic          commit_o,
    output logic [AW-1:0] commit_pc_o,
    output logic          drop_o,
    output logic          pu_valid_o,
    output logic [AW-1:0] pu_pc_o,
    output logic [AW-1:0] pu_npc_o,
    output logic          pu_taken_o,
    output logic          pu_mispred_o,
    output logic [1:0]    pu_type_o
);
    localparam int DW = 2 * AW + 1;

    logic          q_full, q_empty, q_pop, redir_deq;
    logic [DW-1:0] q_rdata;
    logic          head_ep;
    ctrl_type_e    rq_type;

    fr_fetch_unit #(.AW(AW), .RESET_PC(RESET_PC)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .redir_valid   (pu_valid_o),
        .redir_mispred (pu_mispred_o),
        .redir_npc     (pu_npc_o),
        .hazard        (hazard_i),
        .q_full        (q_full),
        .pred_npc      (pq_npc_i),
        .pc            (pq_pc_o),
        .epoch         (issue_epoch_o),
        .issue         (issue_o),
        .redir_deq     (redir_deq)
    );

    fr_fwd_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (issue_o),
        .wdata ({pq_pc_o, pq_npc_i, issue_epoch_o}),
        .pop   (q_pop),
        .rdata (q_rdata),
        .empty (q_empty),
        .full  (q_full)
    );

    assign ex_pc_o     = q_rdata[DW-1 -: AW];
    assign ex_ppc_o    = q_rdata[AW : 1];
    assign head_ep     = q_rdata[0];
    assign commit_pc_o = ex_pc_o;

    fr_exec_unit #(.AW(AW)) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (~q_empty),
        .head_pc    (ex_pc_o),
        .head_ppc   (ex_ppc_o),
        .head_ep    (head_ep),
        .hold       (ex_hold_i),
        .act_npc    (ex_npc_i),
        .act_type   (ctrl_type_e'(ex_type_i)),
        .act_taken  (ex_taken_i),
        .rq_deq     (redir_deq),
        .pop        (q_pop),
        .commit     (commit_o),
        .drop       (drop_o),
        .rq_valid   (pu_valid_o),
        .rq_pc      (pu_pc_o),
        .rq_npc     (pu_npc_o),
        .rq_taken   (pu_taken_o),
        .rq_mispred (pu_mispred_o),
        .rq_type    (rq_type)
    );

    assign pu_type_o = rq_type;

endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] pq_pc_o,
    input logic          issue_o,
    input logic          issue_epoch_o,
    input logic          hazard_i,
    input logic          ex_hold_i,
    input logic          commit_o,
    input logic          drop_o,
    input logic          pu_valid_o,
    input logic          pu_mispred_o,
    input logic [AW-1:0] pu_npc_o
);
    AST_REDIR_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        pu_valid_o |-> !issue_o); // R7

    AST_MISPRED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_valid_o && pu_mispred_o) |=> (pq_pc_o == $past(pu_npc_o)) && (issue_epoch_o != $past(issue_epoch_o))); // R7

    AST_CORRECT_PC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_valid_o && !pu_mispred_o) |=> $stable(pq_pc_o) && $stable(issue_epoch_o)); // R8

    AST_HAZARD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pu_valid_o && hazard_i) |-> !issue_o); // R3

    AST_HAZARD_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pu_valid_o && hazard_i) |=> $stable(pq_pc_o)); // R3

    AST_RECORD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pu_valid_o |=> !pu_valid_o); // R6

    AST_HOLD_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ex_hold_i |-> (!commit_o && !drop_o)); // R9

endmodule

bind fr_fetch_redirect fr_checker #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pq_pc_o       (pq_pc_o),
    .issue_o       (issue_o),
    .issue_epoch_o (issue_epoch_o),
    .hazard_i      (hazard_i),
    .ex_hold_i     (ex_hold_i),
    .commit_o      (commit_o),
    .drop_o        (drop_o),
    .pu_valid_o    (pu_valid_o),
    .pu_mispred_o  (pu_mispred_o),
    .pu_npc_o      (pu_npc_o)
);

// File: tb/sim_fr_fetch_redirect.sv
`timescale 1ns/1ps
module sim_fr_fetch_redirect;
    localparam int          AW    = 32;
    localparam int          DEPTH = 2;
    localparam logic [31:0] RPC   = 32'h0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hazard_i = 1'b0;
    logic        ex_hold_i = 1'b0;
    logic [31:0] pq_pc_o, pq_npc_i, ex_pc_o, ex_ppc_o, ex_npc_i, commit_pc_o, pu_pc_o, pu_npc_o;
    logic [1:0]  ex_type_i, pu_type_o;
    logic        issue_o, issue_epoch_o, ex_taken_i, commit_o, drop_o;
    logic        pu_valid_o, pu_taken_o, pu_mispred_o;

    always #2 clk = ~clk;

    // Architectural program: branch at 0x20 taken to 0x80, jump at 0x90 to 0x40,
    // branch at 0x50 not taken, register jump at 0x60 back to 0x0.
    function automatic logic [31:0] f_npc(input logic [31:0] pc);
        case (pc)
            32'h20:  return 32'h80;
            32'h90:  return 32'h40;
            32'h60:  return 32'h0;
            default: return pc + 32'd4;
        endcase
    endfunction

    function automatic logic [1:0] f_type(input logic [31:0] pc);
        case (pc)
            32'h20, 32'h50: return 2'd3;
            32'h90:         return 2'd1;
            32'h60:         return 2'd2;
            default:        return 2'd0;
        endcase
    endfunction

    function automatic logic f_taken(input logic [31:0] pc);
        return (f_type(pc) != 2'd0) && (f_npc(pc) != pc + 32'd4);
    endfunction

    // Predictor: knows the jump at 0x90, aliases 0x40 onto a stale target.
    function automatic logic [31:0] f_pred(input logic [31:0] pc);
        case (pc)
            32'h90:  return 32'h40;
            32'h40:  return 32'h200;
            default: return pc + 32'd4;
        endcase
    endfunction

    assign pq_npc_i   = f_pred(pq_pc_o);
    assign ex_npc_i   = f_npc(ex_pc_o);
    assign ex_type_i  = f_type(ex_pc_o);
    assign ex_taken_i = f_taken(ex_pc_o);

    fr_fetch_redirect #(.AW(AW), .DEPTH(DEPTH), .RESET_PC(RPC)) u0 (
        .clk(clk), .rst_n(rst_n), .hazard_i(hazard_i),
        .pq_pc_o(pq_pc_o), .pq_npc_i(pq_npc_i),
        .issue_o(issue_o), .issue_epoch_o(issue_epoch_o),
        .ex_hold_i(ex_hold_i), .ex_pc_o(ex_pc_o), .ex_ppc_o(ex_ppc_o),
        .ex_npc_i(ex_npc_i), .ex_type_i(ex_type_i), .ex_taken_i(ex_taken_i),
        .commit_o(commit_o), .commit_pc_o(commit_pc_o), .drop_o(drop_o),
        .pu_valid_o(pu_valid_o), .pu_pc_o(pu_pc_o), .pu_npc_o(pu_npc_o),
        .pu_taken_o(pu_taken_o), .pu_mispred_o(pu_mispred_o), .pu_type_o(pu_type_o)
    );

    int checks = 0;
    int fails  = 0;
    int n_mis = 0, n_drop = 0, n_nt = 0, n_full = 0, n_wait = 0;
    bit done = 1'b0;

    logic [31:0] exp_pc, exp_commit;
    bit          exp_fep, exp_eep;
    bit          rec_pend, rec_tk, rec_mis;
    logic [31:0] rec_pc, rec_npc;
    logic [1:0]  rec_ty;
    logic [31:0] qpc[$];
    logic [31:0] qppc[$];
    bit          qep[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic model_step();
        bit          e_issue, e_commit, e_drop, hmis, nr, hep, n_pend;
        logic [31:0] hpc, hppc;
        e_commit = 1'b0;
        e_drop   = 1'b0;
        hmis     = 1'b0;
        nr       = 1'b0;
        hpc      = '0;
        n_pend   = 1'b0;

        chk(pq_pc_o == exp_pc, "R2 fetch pc", pq_pc_o, exp_pc);
        chk(issue_epoch_o == exp_fep, "R7 fetch epoch", {31'd0, issue_epoch_o}, {31'd0, exp_fep});
        chk(pu_valid_o == rec_pend, "R6 record valid", {31'd0, pu_valid_o}, {31'd0, rec_pend});
        if (rec_pend && pu_valid_o) begin
            chk(pu_pc_o == rec_pc, "R6 record pc", pu_pc_o, rec_pc);
            chk(pu_npc_o == rec_npc, "R6 record npc", pu_npc_o, rec_npc);
            chk(pu_taken_o == rec_tk, "R6 record taken", {31'd0, pu_taken_o}, {31'd0, rec_tk});
            chk(pu_type_o == rec_ty, "R6 record type", {30'd0, pu_type_o}, {30'd0, rec_ty});
            chk(pu_mispred_o == rec_mis, "R5 record mispredict", {31'd0, pu_mispred_o}, {31'd0, rec_mis});
            if (rec_ty == 2'd3 && !rec_tk) n_nt++;
        end

        e_issue = !rec_pend && !hazard_i && (qpc.size() < DEPTH);
        if (!rec_pend && !hazard_i && qpc.size() == DEPTH) n_full++;
        chk(issue_o == e_issue, "R3 issue decision", {31'd0, issue_o}, {31'd0, e_issue});

        if (qpc.size() > 0) begin
            hpc  = qpc[0];
            hppc = qppc[0];
            hep  = qep[0];
            chk(ex_pc_o == hpc, "R2 tagged pc", ex_pc_o, hpc);
            chk(ex_ppc_o == hppc, "R2 tagged predicted pc", ex_ppc_o, hppc);
            hmis = (f_npc(hpc) != hppc);
            nr   = (f_type(hpc) != 2'd0) || hmis;
            if (ex_hold_i) begin
            end else if (hep != exp_eep) begin
                e_drop = 1'b1;
            end else if (nr && rec_pend) begin
                n_wait++;
            end else begin
                e_commit = 1'b1;
            end
        end
        chk(drop_o == e_drop, "R4 drop", {31'd0, drop_o}, {31'd0, e_drop});
        chk(commit_o == e_commit, "R9 commit", {31'd0, commit_o}, {31'd0, e_commit});
        if (commit_o && e_commit) begin
            chk(commit_pc_o == exp_commit, "R10 committed trace", commit_pc_o, exp_commit);
        end

        // execute side update
        if (e_drop) begin
            void'(qpc.pop_front());
            void'(qppc.pop_front());
            void'(qep.pop_front());
            n_drop++;
        end
        if (e_commit) begin
            void'(qpc.pop_front());
            void'(qppc.pop_front());
            void'(qep.pop_front());
            exp_commit = f_npc(hpc);
            if (nr) n_pend = 1'b1;
            if (hmis) begin
                exp_eep = ~exp_eep;
                n_mis++;
            end
        end

        // fetch side update
        if (rec_pend && rec_mis) begin
            exp_pc  = rec_npc;
            exp_fep = ~exp_fep;
        end else if (e_issue) begin
            qpc.push_back(exp_pc);
            qppc.push_back(f_pred(exp_pc));
            qep.push_back(exp_fep);
            exp_pc = f_pred(exp_pc);
        end

        rec_pend = n_pend;
        if (n_pend) begin
            rec_pc  = hpc;
            rec_npc = f_npc(hpc);
            rec_tk  = f_taken(hpc);
            rec_ty  = f_type(hpc);
            rec_mis = hmis;
        end
    endtask

    initial begin
        exp_pc     = RPC;
        exp_commit = RPC;
        exp_fep    = 1'b0;
        exp_eep    = 1'b0;
        rec_pend   = 1'b0;
        rec_tk     = 1'b0;
        rec_mis    = 1'b0;
        rec_pc     = '0;
        rec_npc    = '0;
        rec_ty     = '0;

        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(pq_pc_o == RPC, "R1 reset pc", pq_pc_o, RPC);
            chk(issue_epoch_o == 1'b0, "R1 reset epoch", {31'd0, issue_epoch_o}, 32'd0);
            chk(pu_valid_o == 1'b0, "R1 reset record", {31'd0, pu_valid_o}, 32'd0);
            chk(commit_o == 1'b0 && drop_o == 1'b0, "R1 reset retire", {30'd0, commit_o, drop_o}, 32'd0);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            model_step();
            @(posedge clk);
            #1;
            if (c >= 400 && c < 415) begin
                hazard_i  = 1'b0;
                ex_hold_i = 1'b1;
            end else begin
                hazard_i  = ($urandom_range(0, 4) == 0);
                ex_hold_i = ($urandom_range(0, 3) == 0);
            end
        end

        chk(n_mis >= 3, "R5 mispredicts seen", n_mis, 3);
        chk(n_drop > 0, "R4 wrong-path drops seen", n_drop, 1);
        chk(n_nt > 0, "R6 not-taken records seen", n_nt, 1);
        chk(n_full > 0, "R3 full-queue stalls seen", n_full, 1);
        chk(n_wait > 0, "R9 slot-busy waits seen", n_wait, 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule